// File: doc/BRIEF.md
# Host Adapter Command Port

This block is the adapter-side end of a byte-wide register port through which a host processor drives a storage host adapter. A two-bit address selects one of three registers. A write to offset 0 goes to a control register. A read of offset 0 returns the adapter status. Offset 1 takes command and parameter bytes on writes and returns reply bytes on reads. Offset 2 is a read-only interrupt summary.

The host writes an opcode. It then supplies the parameter bytes that opcode needs, one at a time, and waits on a busy flag between bytes. The reply bytes come back through the data-in register while a ready flag is high. Completion is reported through a command-complete interrupt bit. A small table inside the block fixes the parameter and reply lengths of each opcode and computes the canned reply contents. Unknown opcodes are rejected with an invalid flag. The start-mailbox opcode does not complete like the others: it only emits a one-cycle pulse to the mailbox engine, which lies outside the block. The control register carries hard, soft, interrupt and bus reset requests.

Top module: `hacp_port`

## Requirements
- R1: After `rst_n` is released, or after a control write with bit 7 set (hard reset), the status register reads exactly 0x30 (init-required bit 5, adapter-ready bit 4) and the interrupt register reads 0x00.
- R2: Reads decode as follows: offset 0 returns status, offset 1 returns the current reply byte (0x00 when none is pending), offset 2 returns interrupts and offset 3 returns 0x00. Writes to offsets 2 and 3 have no effect.
- R3: A byte accepted at offset 1 sets status bit 3 (busy) for exactly CONSUME_LAT cycles (default 2). A write to offset 1 while busy is set is discarded.
- R4: Adapter-ready (status bit 4) clears when any opcode other than 0x02 is accepted. It stays clear until the command completes or is abandoned.
- R5: Opcode 0x04 takes no parameters and replies 0x40, 0x41, 0x42, 0x43. Status bit 2 (data-in ready) is high while a reply byte is unread. Each read at offset 1 consumes one byte. Reading the last byte completes the command.
- R6: Opcode 0x0B takes no parameters and replies 0x20, 0x40, ADAPTER_ID.
- R7: Opcode 0x8D takes one parameter N and replies min(N, MAX_REPLY) bytes: byte 0 is 0x45 and byte i (i > 0) equals i. When N = 0 the command completes with no reply.
- R8: Opcode 0x01 takes four parameters and gives no reply. On completion it clears the init-required bit.
- R9: Opcode 0x02 leaves adapter-ready set and raises no command-complete interrupt. Once it is consumed, `mbox_start` pulses for one cycle. It is also accepted while a reply is still pending, and the pending reply is kept.
- R10: An unknown opcode sets status bit 0 (command invalid) and interrupt bit 2 (command complete). The block then returns to idle with adapter-ready set.
- R11: A control write with bit 5 set clears the whole interrupt register and the command-invalid status bit.
- R12: Interrupt bit 7 (valid) is set exactly when any other interrupt bit is set. The `irq` output follows it.
- R13: A control write with bit 6 set (soft reset) abandons any command, discards pending reply bytes and clears interrupts and command-invalid. The init-required bit keeps its value.
- R14: A control write with bit 4 set raises interrupt bit 3 (bus reset state). This holds even when the same write also requests a hard reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, same effect as hard reset |
| io_addr | input | 2 | Register offset |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_wdata | input | 8 | Write data |
| io_rd | input | 1 | Read strobe; at offset 1 it consumes a reply byte |
| io_rdata | output | 8 | Read data, combinational on io_addr |
| irq | output | 1 | Interrupt request, equal to interrupt bit 7 |
| mbox_start | output | 1 | One-cycle pulse when a start-mailbox opcode is consumed |

## Verification
On every cycle, the assertions check the following cross-module relations: a byte is never taken while busy, busy lasts its full latency, the decode state always has a byte in flight, and reply bytes exist only in the reply state. They also check that a hard reset settles the status to 0x30, that a rejected opcode always leaves the invalid and complete flags, and that the start pulse is a single cycle. Some behaviours can only be shown by the bench's host-style scenarios: the exact reply contents and lengths of each opcode, the loss of a parameter written during busy, clipping of an over-long reply, the survival of a reply across a start-mailbox write, and the partial state kept by a soft reset.

// File: rtl/hacp_pkg.sv
package hacp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DECODE = 2'd1,
    ST_PARAM  = 2'd2,
    ST_REPLY  = 2'd3
  } hacp_state_e;

  localparam logic [7:0] OP_MBOX_INIT = 8'h01;
  localparam logic [7:0] OP_START     = 8'h02;
  localparam logic [7:0] OP_INQUIRY   = 8'h04;
  localparam logic [7:0] OP_CONFIG    = 8'h0B;
  localparam logic [7:0] OP_EXT_SETUP = 8'h8D;

  // Opcode recognised by the command table
  function automatic logic op_known(input logic [7:0] op);
    return (op == OP_MBOX_INIT) || (op == OP_START) || (op == OP_INQUIRY) ||
           (op == OP_CONFIG) || (op == OP_EXT_SETUP);
  endfunction

  // Number of parameter bytes following the opcode
  function automatic logic [2:0] op_param_len(input logic [7:0] op);
    case (op)
      OP_MBOX_INIT: return 3'd4;
      OP_EXT_SETUP: return 3'd1;
      default:      return 3'd0;
    endcase
  endfunction

  // Reply length for opcodes whose reply length is fixed
  function automatic logic [7:0] op_fixed_reply(input logic [7:0] op);
    case (op)
      OP_INQUIRY: return 8'd4;
      OP_CONFIG:  return 8'd3;
      default:    return 8'd0;
    endcase
  endfunction

  // Canned reply byte at position idx
  function automatic logic [7:0] reply_byte(input logic [7:0] op, input logic [7:0] idx,
                                            input logic [2:0] id);
    case (op)
      OP_INQUIRY:   return 8'h40 + idx;
      OP_CONFIG:    return (idx == 8'd0) ? 8'h20 : (idx == 8'd1) ? 8'h40 : {5'd0, id};
      OP_EXT_SETUP: return (idx == 8'd0) ? 8'h45 : idx;
      default:      return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/hacp_accept.sv
module hacp_accept #(
  parameter int LAT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       take,
  input  logic [7:0] wdata,
  output logic       busy,
  output logic       consume,
  output logic [7:0] held
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      held <= 8'h00;
    end else if (clr) begin
      cnt <= '0;
    end else if (take) begin
      cnt  <= CW'(LAT);
      held <= wdata;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign busy    = (cnt != '0);
  assign consume = (cnt == CW'(1));

  // R3: the front end never hands over a byte while one is in flight
  assert_no_take_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !busy);

  // R3: a freshly accepted byte keeps busy for more than one cycle
  assert_busy_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(LAT) && !clr) |=> busy);

endmodule

// File: rtl/hacp_reply.sv
module hacp_reply #(
  parameter int MAX = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         load,
  input  logic [$clog2(MAX+1)-1:0]     ld_len,
  input  logic                         pop,
  output logic                         avail,
  output logic                         last,
  output logic [7:0]                   idx8
);
  localparam int LW = $clog2(MAX + 1);

  logic [LW-1:0] len;
  logic [LW-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len <= '0;
      idx <= '0;
    end else if (clr) begin
      len <= '0;
      idx <= '0;
    end else if (load) begin
      len <= ld_len;
      idx <= '0;
    end else if (pop && avail) begin
      idx <= idx + 1'b1;
    end
  end

  assign avail = (idx < len);
  assign last  = pop && avail && (idx == len - 1'b1);
  assign idx8  = 8'(idx);

  // R7: the read index never runs past the loaded length
  assert_idx_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= len);

  // R5: consuming the final byte drops data-in ready
  assert_last_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !clr && !load) |=> !avail);

endmodule

// File: rtl/hacp_intr.sv
module hacp_intr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       set_cmdc,
  input  logic       set_sres,
  output logic [7:0] intr_byte
);
  logic cmdc_q;
  logic sres_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdc_q <= 1'b0;
      sres_q <= 1'b0;
    end else begin
      cmdc_q <= !clr && (cmdc_q || set_cmdc);
      sres_q <= set_sres || (!clr && sres_q);
    end
  end

  assign intr_byte = {(cmdc_q || sres_q), 3'b000, sres_q, cmdc_q, 2'b00};

  // R11: a clear with no bus-reset request empties the register
  assert_clear_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_sres) |=> (intr_byte == 8'h00));

endmodule

// File: rtl/hacp_port.sv
module hacp_port
  import hacp_pkg::*;
#(
  parameter int CONSUME_LAT = 2,
  parameter int MAX_REPLY   = 16,
  parameter int ADAPTER_ID  = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] io_addr,
  input  logic       io_wr,
  input  logic [7:0] io_wdata,
  input  logic       io_rd,
  output logic [7:0] io_rdata,
  output logic       irq,
  output logic       mbox_start
);
  localparam int LW = $clog2(MAX_REPLY + 1);
  localparam logic [7:0] MAX8 = 8'(MAX_REPLY);

  hacp_state_e state, state_n;
  logic [7:0]  cur_op, op_n;
  logic [2:0]  pcnt, pcnt_n;
  logic        init_req, cmd_inv, start_q;

  // Decoded port events
  logic ctl_wr, cpr_wr, din_rd;
  logic hard_rst, soft_rst, wipe, int_rst, bus_rst;
  assign ctl_wr   = io_wr && (io_addr == 2'd0);
  assign cpr_wr   = io_wr && (io_addr == 2'd1);
  assign din_rd   = io_rd && (io_addr == 2'd1);
  assign hard_rst = ctl_wr && io_wdata[7];
  assign soft_rst = ctl_wr && io_wdata[6] && !io_wdata[7];
  assign wipe     = hard_rst || soft_rst;
  assign int_rst  = ctl_wr && io_wdata[5];
  assign bus_rst  = ctl_wr && io_wdata[4];

  // Internal events, named for the assertions
  logic          busy, consume, take;
  logic [7:0]    held;
  logic          avail, last_pop;
  logic [7:0]    ridx;
  logic          load;
  logic [LW-1:0] ld_len;
  logic          done, bad, start_n, init_clr, set_cmdc;
  logic [7:0]    rl;
  logic [7:0]    intr_byte, status_byte;

  assign take = cpr_wr && !busy && !wipe &&
                ((state == ST_IDLE) || (state == ST_PARAM) ||
                 ((state == ST_REPLY) && (io_wdata == OP_START)));

  hacp_accept #(.LAT(CONSUME_LAT)) u_accept (
    .clk(clk), .rst_n(rst_n), .clr(wipe), .take(take), .wdata(io_wdata),
    .busy(busy), .consume(consume), .held(held)
  );

  hacp_reply #(.MAX(MAX_REPLY)) u_reply (
    .clk(clk), .rst_n(rst_n), .clr(wipe), .load(load), .ld_len(ld_len),
    .pop(din_rd && !wipe), .avail(avail), .last(last_pop), .idx8(ridx)
  );

  hacp_intr u_intr (
    .clk(clk), .rst_n(rst_n), .clr(wipe || int_rst),
    .set_cmdc(set_cmdc && !wipe), .set_sres(bus_rst), .intr_byte(intr_byte)
  );

  // Command sequencing
  always_comb begin
    state_n  = state;
    op_n     = cur_op;
    pcnt_n   = pcnt;
    done     = 1'b0;
    bad      = 1'b0;
    load     = 1'b0;
    ld_len   = '0;
    start_n  = 1'b0;
    rl       = 8'h00;
    if (take && (state == ST_IDLE) && (io_wdata != OP_START))
      state_n = ST_DECODE;
    if (consume) begin
      case (state)
        ST_IDLE, ST_REPLY: start_n = (held == OP_START);
        ST_DECODE: begin
          op_n = held;
          if (!op_known(held)) begin
            bad     = 1'b1;
            state_n = ST_IDLE;
          end else if (op_param_len(held) != 3'd0) begin
            pcnt_n  = 3'd0;
            state_n = ST_PARAM;
          end else if (op_fixed_reply(held) != 8'd0) begin
            load    = 1'b1;
            ld_len  = LW'(op_fixed_reply(held));
            state_n = ST_REPLY;
          end else begin
            done    = 1'b1;
            state_n = ST_IDLE;
          end
        end
        ST_PARAM: begin
          pcnt_n = pcnt + 3'd1;
          if (pcnt + 3'd1 == op_param_len(cur_op)) begin
            rl = (cur_op == OP_EXT_SETUP) ? ((held > MAX8) ? MAX8 : held)
                                          : op_fixed_reply(cur_op);
            if (rl == 8'd0) begin
              done    = 1'b1;
              state_n = ST_IDLE;
            end else begin
              load    = 1'b1;
              ld_len  = LW'(rl);
              state_n = ST_REPLY;
            end
          end
        end
        default: ;
      endcase
    end
    if (last_pop && (state == ST_REPLY)) begin
      done    = 1'b1;
      state_n = ST_IDLE;
    end
  end

  assign init_clr = done && (op_n == OP_MBOX_INIT);
  assign set_cmdc = done || bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_op   <= 8'h00;
      pcnt     <= 3'd0;
      init_req <= 1'b1;
      cmd_inv  <= 1'b0;
      start_q  <= 1'b0;
    end else if (hard_rst) begin
      state    <= ST_IDLE;
      cur_op   <= 8'h00;
      pcnt     <= 3'd0;
      init_req <= 1'b1;
      cmd_inv  <= 1'b0;
      start_q  <= 1'b0;
    end else if (soft_rst) begin
      state    <= ST_IDLE;
      pcnt     <= 3'd0;
      cmd_inv  <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      state    <= state_n;
      cur_op   <= op_n;
      pcnt     <= pcnt_n;
      init_req <= init_req && !init_clr;
      cmd_inv  <= (cmd_inv && !int_rst) || bad;
      start_q  <= start_n;
    end
  end

  assign status_byte = {2'b00, init_req, (state == ST_IDLE), busy, avail, 1'b0, cmd_inv};

  always_comb begin
    case (io_addr)
      2'd0:    io_rdata = status_byte;
      2'd1:    io_rdata = avail ? reply_byte(cur_op, ridx, 3'(ADAPTER_ID)) : 8'h00;
      2'd2:    io_rdata = intr_byte;
      default: io_rdata = 8'h00;
    endcase
  end

  assign irq        = intr_byte[7];
  assign mbox_start = start_q;

  // R1: a hard reset through the control register settles to 0x30
  assert_hard_settle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hard_rst |=> (status_byte == 8'h30));

  // R4: while an opcode is being decoded a byte is always in flight
  assert_decode_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DECODE) |-> busy);

  // R5: reply bytes exist only in the reply state
  assert_reply_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    avail |-> (state == ST_REPLY));

  // R9: the mailbox start strobe lasts a single cycle
  assert_start_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mbox_start |=> !mbox_start);

  // R10: a rejected opcode leaves both the invalid and complete flags
  assert_invalid_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bad && !wipe && !int_rst) |=> (cmd_inv && intr_byte[2]));

endmodule

// File: tb/sim_hacp_port.sv
module sim_hacp_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] io_addr;
  logic       io_wr, io_rd;
  logic [7:0] io_wdata;
  wire  [7:0] io_rdata;
  wire        irq, mbox_start;

  int n_chk = 0;
  int n_fail = 0;
  int starts = 0;

  always #10 clk = ~clk;

  hacp_port u0 (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
    .io_rd(io_rd), .io_rdata(io_rdata), .irq(irq), .mbox_start(mbox_start)
  );

  always @(posedge clk) if (mbox_start) starts <= starts + 1;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    io_addr = a; io_rd = 1'b1;
    #1 v = io_rdata;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic wait_status(input logic [7:0] mask, input logic [7:0] val, input string tag);
    logic [7:0] s;
    for (int i = 0; i < 64; i++) begin
      rd(2'd0, s);
      if ((s & mask) == val) return;
    end
    check(tag, s & mask, val);
  endtask

  task automatic param(input logic [7:0] b);
    wait_status(8'h08, 8'h00, "R3 busy never cleared");
    wr(2'd1, b);
  endtask

  task automatic expect_byte(input logic [7:0] exp, input string tag);
    logic [7:0] v;
    rd(2'd1, v);
    check(tag, v, exp);
  endtask

  task automatic clear_intr();
    wr(2'd0, 8'h20);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); check("R1 status after reset", v, 8'h30);
    rd(2'd2, v); check("R1 interrupts after reset", v, 8'h00);
    rd(2'd3, v); check("R2 offset 3 reads zero", v, 8'h00);
    rd(2'd1, v); check("R2 empty data-in reads zero", v, 8'h00);
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'hFF);
    rd(2'd2, v); check("R2 write to offset 2 ignored", v, 8'h00);
    rd(2'd0, v); check("R2 status unchanged", v, 8'h30);
  endtask

  task automatic t_latency();
    logic [7:0] v;
    wr(2'd1, 8'h04);
    rd(2'd0, v); check("R3 busy first cycle / R4 ready low", v & 8'h18, 8'h08);
    rd(2'd0, v); check("R3 busy second cycle", v & 8'h18, 8'h08);
    rd(2'd0, v); check("R3 busy released, R5 data-in ready", v & 8'h1C, 8'h04);
    expect_byte(8'h40, "R5 inquiry byte 0");
    expect_byte(8'h41, "R5 inquiry byte 1");
    rd(2'd0, v); check("R4 ready low during reply", v & 8'h14, 8'h04);
    expect_byte(8'h42, "R5 inquiry byte 2");
    expect_byte(8'h43, "R5 inquiry byte 3");
    rd(2'd0, v); check("R5 complete: ready, no data", v & 8'h1C, 8'h10);
    rd(2'd2, v); check("R5 command complete interrupt", v, 8'h84);
    clear_intr();
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    wr(2'd1, 8'h04);
    rd(2'd0, v);
    wr(2'd1, 8'h0B);
    wait_status(8'h04, 8'h04, "R3 reply never ready");
    for (int i = 0; i < 4; i++) expect_byte(8'h40 + 8'(i), "R3 write during busy discarded");
    rd(2'd0, v); check("R3 no extra bytes", v & 8'h04, 8'h00);
    clear_intr();
  endtask

  task automatic t_config();
    logic [7:0] v;
    wr(2'd1, 8'h0B);
    wait_status(8'h04, 8'h04, "R6 reply never ready");
    expect_byte(8'h20, "R6 config byte 0");
    expect_byte(8'h40, "R6 config byte 1");
    expect_byte(8'h07, "R6 config byte 2 adapter id");
    rd(2'd0, v); check("R6 done", v & 8'h1C, 8'h10);
    rd(2'd2, v); check("R6 complete interrupt", v, 8'h84);
    clear_intr();
  endtask

  task automatic t_ext();
    logic [7:0] v;
    wr(2'd1, 8'h8D); param(8'd3);
    wait_status(8'h04, 8'h04, "R7 reply never ready");
    expect_byte(8'h45, "R7 ext byte 0");
    expect_byte(8'h01, "R7 ext byte 1");
    expect_byte(8'h02, "R7 ext byte 2");
    rd(2'd0, v); check("R7 length 3 honoured", v & 8'h1C, 8'h10);
    clear_intr();
    wr(2'd1, 8'h8D); param(8'd0);
    wait_status(8'h08, 8'h00, "R7 busy stuck");
    rd(2'd0, v); check("R7 zero length: no data, ready", v & 8'h1C, 8'h10);
    rd(2'd2, v); check("R7 zero length completes", v, 8'h84);
    clear_intr();
    wr(2'd1, 8'h8D); param(8'd40);
    wait_status(8'h04, 8'h04, "R7 reply never ready");
    expect_byte(8'h45, "R7 long byte 0");
    for (int i = 1; i < 16; i++) expect_byte(8'(i), "R7 long reply byte");
    rd(2'd0, v); check("R7 reply clipped to 16", v & 8'h04, 8'h00);
    clear_intr();
  endtask

  task automatic t_invalid();
    logic [7:0] v;
    wr(2'd1, 8'h55);
    wait_status(8'h08, 8'h00, "R10 busy stuck");
    rd(2'd0, v); check("R10 invalid flag and ready", v & 8'h1D, 8'h11);
    rd(2'd2, v); check("R10 complete interrupt", v, 8'h84);
    check("R12 irq follows valid", {7'd0, irq}, 8'h01);
    clear_intr();
    rd(2'd2, v); check("R11 interrupts cleared", v, 8'h00);
    rd(2'd0, v); check("R11 invalid cleared", v & 8'h01, 8'h00);
    check("R12 irq dropped", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_start();
    logic [7:0] v;
    int s0;
    s0 = starts;
    wr(2'd1, 8'h02);
    rd(2'd0, v); check("R9 ready kept while busy", v & 8'h18, 8'h18);
    wait_status(8'h08, 8'h00, "R9 busy stuck");
    rd(2'd0, v);
    check("R9 one start pulse", 8'(starts - s0), 8'd1);
    rd(2'd2, v); check("R9 no complete interrupt", v, 8'h00);
    wr(2'd1, 8'h04);
    wait_status(8'h04, 8'h04, "R9 reply never ready");
    wr(2'd1, 8'h02);
    wait_status(8'h08, 8'h00, "R9 busy stuck");
    rd(2'd0, v);
    check("R9 start accepted during reply", 8'(starts - s0), 8'd2);
    for (int i = 0; i < 4; i++) expect_byte(8'h40 + 8'(i), "R9 reply kept");
    rd(2'd2, v); check("R9 reply still completes", v, 8'h84);
    clear_intr();
  endtask

  task automatic t_init();
    logic [7:0] v;
    rd(2'd0, v); check("R8 init required before", v & 8'h20, 8'h20);
    wr(2'd1, 8'h01);
    param(8'h08); param(8'h00); param(8'h10);
    wait_status(8'h08, 8'h00, "R8 busy stuck");
    rd(2'd0, v); check("R8 not ready mid-parameters", v & 8'h30, 8'h20);
    param(8'h00);
    wait_status(8'h08, 8'h00, "R8 busy stuck");
    rd(2'd0, v); check("R8 init cleared, ready", v, 8'h10);
    rd(2'd2, v); check("R8 complete interrupt", v, 8'h84);
    clear_intr();
  endtask

  task automatic t_sbus();
    logic [7:0] v;
    wr(2'd0, 8'h10);
    rd(2'd2, v); check("R14 bus reset state bit", v, 8'h88);
    check("R12 irq on bus reset", {7'd0, irq}, 8'h01);
    clear_intr();
    rd(2'd2, v); check("R11 bus reset bit cleared", v, 8'h00);
  endtask

  task automatic t_soft();
    logic [7:0] v;
    wr(2'd1, 8'h04);
    wait_status(8'h04, 8'h04, "R13 reply never ready");
    expect_byte(8'h40, "R13 first byte");
    wr(2'd0, 8'h40);
    rd(2'd0, v); check("R13 soft reset status keeps init clear", v, 8'h10);
    rd(2'd1, v); check("R13 reply discarded", v, 8'h00);
    rd(2'd2, v); check("R13 interrupts cleared", v, 8'h00);
    wr(2'd1, 8'h0B);
    wait_status(8'h04, 8'h04, "R13 reply never ready");
    expect_byte(8'h20, "R13 new command after soft reset");
    wr(2'd0, 8'h40);
  endtask

  task automatic t_hard();
    logic [7:0] v;
    wr(2'd1, 8'h8D);
    wr(2'd0, 8'h90);
    rd(2'd0, v); check("R1 hard reset status", v, 8'h30);
    rd(2'd2, v); check("R14 bus reset with hard reset", v, 8'h88);
    clear_intr();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; io_addr = 2'd0; io_wr = 1'b0; io_rd = 1'b0; io_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_overrun();
    t_config();
    t_ext();
    t_invalid();
    t_start();
    t_init();
    t_sbus();
    t_soft();
    t_hard();
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

endmodule